// File: doc/BRIEF.md
# Doorbell Queue Pointer Tracker

This block keeps the producer and consumer indices of a set of circular queue pairs whose entries live in host memory. Each pair has a submission ring and a completion ring, and pair 0 is the administrative pair. Software moves one index of each ring by writing a doorbell register. For a submission ring it posts a new tail. For a completion ring it posts a new head. The controller moves the other index with single-cycle advance pulses. For each ring the block reports empty and full, the number of occupied entries, and the slot the controller should use next.

Ring sizes are loaded through a small configuration port as a zero-based entry count. A ring is full when one slot is still unused, so a ring of N entries holds at most N-1 items. The block checks every doorbell value before accepting it. A value outside the ring, a write that would take back posted work, or a write to a ring not yet created is dropped and flagged. Doorbell writes enter through a valid/ready port. Ready is held high in every cycle after reset, so the source never stalls, and a write counts only in a cycle where valid and ready are both high. Configuration, advance and error pins are plain level or pulse signals.

Top module: `queue_tracker`

## Requirements
- R1: After reset every ring shows empty=1, full=0, count 0, slot 0, and all three error pulses are low.
- R2: A configuration write with size field S creates the selected ring with S+1 entries and sets both of its indices to 0, including when the ring already existed. S=0 is refused, and the refusal pulses cfg_err in the next cycle. A configuration write to a qid of NUM_QP or more also pulses cfg_err.
- R3: The size field of qid 0 may be at most ADMIN_MAX-1 (4095 by default). The size field of any other qid may be at most IO_MAX-1 (65535 by default). Larger values are refused with cfg_err.
- R4: The doorbell for the submission tail of queue q is at byte address 0x1000+8q. The doorbell for the completion head of queue q is at 0x1000+8q+4. A write that is misaligned, below 0x1000, or that maps to a qid of NUM_QP or more changes no state and pulses db_err in the next cycle.
- R5: A submission tail doorbell sets the tail to the written value. The count is (tail-head) mod N, empty means count 0, full means count N-1, and the submission slot output is the head.
- R6: A cq_adv pulse moves the completion tail forward by one. A completion head doorbell sets the head to the written value. The completion slot output is the tail.
- R7: An index that moves forward from N-1 wraps to 0.
- R8: A doorbell value of N or more is ignored and pulses db_err in the next cycle.
- R9: A submission tail doorbell that would lower the count is ignored with db_err. So is a completion head doorbell that moves the head further than the current count.
- R10: A doorbell to a ring that has not been created is ignored with db_err.
- R11: sq_adv on an empty submission ring, and cq_adv on a full or uncreated completion ring, is ignored and pulses adv_err in the next cycle.
- R12: db_ready is high in every cycle after the first clock edge out of reset.
- R13: A doorbell and an advance on the same ring in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_qid | input | QID_W | Queue pair selected for configuration |
| cfg_cq | input | 1 | 0 selects the submission ring, 1 the completion ring |
| cfg_size | input | PTR_W | Zero-based entry count |
| cfg_err | output | 1 | Refused configuration, one-cycle pulse |
| db_valid | input | 1 | Doorbell write valid |
| db_ready | output | 1 | Doorbell write ready |
| db_addr | input | ADDR_W | Doorbell byte address |
| db_data | input | PTR_W | New index value |
| db_err | output | 1 | Rejected doorbell, one-cycle pulse |
| sq_adv | input | NUM_QP | Controller consumed one submission entry, per qid |
| cq_adv | input | NUM_QP | Controller posted one completion entry, per qid |
| adv_err | output | 1 | Rejected advance, one-cycle pulse |
| sq_empty | output | NUM_QP | Submission ring empty, per qid |
| sq_full | output | NUM_QP | Submission ring full, per qid |
| cq_empty | output | NUM_QP | Completion ring empty, per qid |
| cq_full | output | NUM_QP | Completion ring full, per qid |
| sq_count | output | NUM_QP*PTR_W | Submission occupancy, qid q at bits q*PTR_W |
| cq_count | output | NUM_QP*PTR_W | Completion occupancy, qid q at bits q*PTR_W |
| sq_slot | output | NUM_QP*PTR_W | Next submission slot to fetch (head) |
| cq_slot | output | NUM_QP*PTR_W | Next completion slot to write (tail) |

## Verification
The bench builds the tracker with NUM_QP=3, so the doorbell at 0x1018 falls outside the map, and qid 2 stays uncreated long enough to test refusals. The size limits keep their defaults of 4096 and 65536. This lets the bench fill a 65536-entry I/O ring with the full 16-bit index 65535, and probe the limit of the administrative pair at 4095 and 4096. Small rings of 3 and 4 entries make the wraparound, the full point and the retreat checks reachable within a few doorbell writes.

// File: rtl/qt_pkg.sv
package qt_pkg;
  // Byte address of the first doorbell register
  localparam int unsigned DB_BASE = 32'h1000;
  // Two doorbells (submission tail, completion head) per queue pair
  localparam int unsigned DB_PAIR_SHIFT = 3;

  typedef enum logic {
    SIDE_SQ = 1'b0,
    SIDE_CQ = 1'b1
  } ring_side_e;
endpackage

// File: rtl/qt_db_decode.sv
module qt_db_decode
  import qt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_QP = 4,
  localparam int QID_W = (NUM_QP > 1) ? $clog2(NUM_QP) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [QID_W-1:0]  qid,
  output ring_side_e        side
);
  localparam int SEL_W = ADDR_W - DB_PAIR_SHIFT;

  logic [ADDR_W-1:0] off;
  logic [SEL_W-1:0]  pair_sel;
  logic              below;

  always_comb begin
    below    = addr < ADDR_W'(DB_BASE);
    off      = addr - ADDR_W'(DB_BASE);
    pair_sel = off[ADDR_W-1:DB_PAIR_SHIFT];
    side     = off[2] ? SIDE_CQ : SIDE_SQ;
    qid      = pair_sel[QID_W-1:0];
    hit      = !below && (off[1:0] == 2'b00) && (pair_sel < SEL_W'(NUM_QP));
  end
endmodule

// File: rtl/qt_ring.sv
module qt_ring #(
  parameter int PTR_W          = 16,
  parameter int MAX_ENTRIES    = 65536,
  parameter bit HOST_PRODUCES  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [PTR_W-1:0] cfg_size,
  input  logic             db_we,
  input  logic [PTR_W-1:0] db_val,
  input  logic             adv,
  output logic             cfg_bad,
  output logic             db_bad,
  output logic             adv_bad,
  output logic             empty,
  output logic             full,
  output logic [PTR_W-1:0] count,
  output logic [PTR_W-1:0] slot
);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] MAX_FIELD = CNT_W'(MAX_ENTRIES - 1);

  logic             live_q;
  logic [PTR_W-1:0] last_q;   // entries minus one
  logic [PTR_W-1:0] prod_q;
  logic [PTR_W-1:0] cons_q;
  logic [CNT_W-1:0] n_ent;
  logic [PTR_W-1:0] db_gap;
  logic             cfg_ok, db_ok, adv_ok;

  function automatic logic [PTR_W-1:0] ring_gap(
    input logic [PTR_W-1:0] from_p,
    input logic [PTR_W-1:0] to_p,
    input logic [CNT_W-1:0] n
  );
    logic [CNT_W-1:0] d;
    if (to_p >= from_p) d = {1'b0, to_p} - {1'b0, from_p};
    else                d = {1'b0, to_p} + n - {1'b0, from_p};
    return d[PTR_W-1:0];
  endfunction

  function automatic logic [PTR_W-1:0] step(
    input logic [PTR_W-1:0] p,
    input logic [PTR_W-1:0] last
  );
    return (p == last) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    n_ent  = {1'b0, last_q} + 1'b1;
    count  = ring_gap(cons_q, prod_q, n_ent);
    empty  = (count == '0);
    full   = live_q && (count == last_q);
    slot   = HOST_PRODUCES ? cons_q : prod_q;
    db_gap = ring_gap(cons_q, db_val, n_ent);

    cfg_bad = cfg_we && ((cfg_size == '0) || ({1'b0, cfg_size} > MAX_FIELD));
    cfg_ok  = cfg_we && !cfg_bad;

    if (HOST_PRODUCES)
      db_bad = db_we && (!live_q || (db_val > last_q) || (db_gap < count));
    else
      db_bad = db_we && (!live_q || (db_val > last_q) || (db_gap > count));
    db_ok = db_we && !db_bad && !cfg_ok;

    adv_bad = adv && (!live_q || (HOST_PRODUCES ? empty : full));
    adv_ok  = adv && !adv_bad && !cfg_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      last_q <= '0;
    end else if (cfg_ok) begin
      live_q <= 1'b1;
      last_q <= cfg_size;
    end
  end

  generate
    if (HOST_PRODUCES) begin : g_host_prod
      // Host writes the producer index, controller consumes
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prod_q <= '0;
          cons_q <= '0;
        end else if (cfg_ok) begin
          prod_q <= '0;
          cons_q <= '0;
        end else begin
          if (db_ok)  prod_q <= db_val;
          if (adv_ok) cons_q <= step(cons_q, last_q);
        end
      end
    end else begin : g_host_cons
      // Controller produces, host writes the consumer index
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prod_q <= '0;
          cons_q <= '0;
        end else if (cfg_ok) begin
          prod_q <= '0;
          cons_q <= '0;
        end else begin
          if (adv_ok) prod_q <= step(prod_q, last_q);
          if (db_ok)  cons_q <= db_val;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/queue_tracker.sv
module queue_tracker
  import qt_pkg::*;
#(
  parameter int NUM_QP    = 4,
  parameter int PTR_W     = 16,
  parameter int ADDR_W    = 16,
  parameter int ADMIN_MAX = 4096,
  parameter int IO_MAX    = 65536,
  localparam int QID_W    = (NUM_QP > 1) ? $clog2(NUM_QP) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [QID_W-1:0]        cfg_qid,
  input  logic                    cfg_cq,
  input  logic [PTR_W-1:0]        cfg_size,
  output logic                    cfg_err,
  input  logic                    db_valid,
  output logic                    db_ready,
  input  logic [ADDR_W-1:0]       db_addr,
  input  logic [PTR_W-1:0]        db_data,
  output logic                    db_err,
  input  logic [NUM_QP-1:0]       sq_adv,
  input  logic [NUM_QP-1:0]       cq_adv,
  output logic                    adv_err,
  output logic [NUM_QP-1:0]       sq_empty,
  output logic [NUM_QP-1:0]       sq_full,
  output logic [NUM_QP-1:0]       cq_empty,
  output logic [NUM_QP-1:0]       cq_full,
  output logic [NUM_QP*PTR_W-1:0] sq_count,
  output logic [NUM_QP*PTR_W-1:0] cq_count,
  output logic [NUM_QP*PTR_W-1:0] sq_slot,
  output logic [NUM_QP*PTR_W-1:0] cq_slot
);
  logic             db_fire;
  logic             db_hit;
  logic [QID_W-1:0] db_qid;
  ring_side_e       db_side;
  logic             cfg_range_bad;

  logic [NUM_QP-1:0] sq_cfg_bad, cq_cfg_bad;
  logic [NUM_QP-1:0] sq_db_bad,  cq_db_bad;
  logic [NUM_QP-1:0] sq_adv_bad, cq_adv_bad;

  assign db_fire       = db_valid && db_ready;
  assign cfg_range_bad = {1'b0, cfg_qid} >= (QID_W+1)'(NUM_QP);

  qt_db_decode #(
    .ADDR_W (ADDR_W),
    .NUM_QP (NUM_QP)
  ) u_decode (
    .addr (db_addr),
    .hit  (db_hit),
    .qid  (db_qid),
    .side (db_side)
  );

  generate
    for (genvar q = 0; q < NUM_QP; q++) begin : g_pair
      localparam int LIMIT = (q == 0) ? ADMIN_MAX : IO_MAX;
      logic sel_cfg, sel_db;
      assign sel_cfg = cfg_we && (cfg_qid == QID_W'(q));
      assign sel_db  = db_fire && db_hit && (db_qid == QID_W'(q));

      qt_ring #(
        .PTR_W         (PTR_W),
        .MAX_ENTRIES   (LIMIT),
        .HOST_PRODUCES (1'b1)
      ) u_sq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (sel_cfg && !cfg_cq),
        .cfg_size (cfg_size),
        .db_we    (sel_db && (db_side == SIDE_SQ)),
        .db_val   (db_data),
        .adv      (sq_adv[q]),
        .cfg_bad  (sq_cfg_bad[q]),
        .db_bad   (sq_db_bad[q]),
        .adv_bad  (sq_adv_bad[q]),
        .empty    (sq_empty[q]),
        .full     (sq_full[q]),
        .count    (sq_count[q*PTR_W +: PTR_W]),
        .slot     (sq_slot[q*PTR_W +: PTR_W])
      );

      qt_ring #(
        .PTR_W         (PTR_W),
        .MAX_ENTRIES   (LIMIT),
        .HOST_PRODUCES (1'b0)
      ) u_cq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (sel_cfg && cfg_cq),
        .cfg_size (cfg_size),
        .db_we    (sel_db && (db_side == SIDE_CQ)),
        .db_val   (db_data),
        .adv      (cq_adv[q]),
        .cfg_bad  (cq_cfg_bad[q]),
        .db_bad   (cq_db_bad[q]),
        .adv_bad  (cq_adv_bad[q]),
        .empty    (cq_empty[q]),
        .full     (cq_full[q]),
        .count    (cq_count[q*PTR_W +: PTR_W]),
        .slot     (cq_slot[q*PTR_W +: PTR_W])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_ready <= 1'b0;
      db_err   <= 1'b0;
      adv_err  <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      db_ready <= 1'b1;
      db_err   <= db_fire && (!db_hit || (|sq_db_bad) || (|cq_db_bad));
      adv_err  <= (|sq_adv_bad) || (|cq_adv_bad);
      cfg_err  <= cfg_we && (cfg_range_bad || (|sq_cfg_bad) || (|cq_cfg_bad));
    end
  end
endmodule

// File: rtl/qt_checker.sv
module qt_checker #(
  parameter int NUM_QP = 4,
  parameter int PTR_W  = 16,
  parameter int ADDR_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_we,
  input logic                    db_valid,
  input logic                    db_ready,
  input logic [ADDR_W-1:0]       db_addr,
  input logic                    db_err,
  input logic [NUM_QP-1:0]       sq_adv,
  input logic [NUM_QP-1:0]       cq_adv,
  input logic                    adv_err,
  input logic [NUM_QP-1:0]       sq_empty,
  input logic [NUM_QP-1:0]       sq_full,
  input logic [NUM_QP-1:0]       cq_full,
  input logic [NUM_QP*PTR_W-1:0] cq_count
);
  // R12: ready follows one edge after reset release
  a_r12_ready_up: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> db_ready);

  // R4: a misaligned doorbell is always flagged
  a_r4_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid && db_ready && (db_addr[1:0] != 2'b00) |=> db_err);

  generate
    for (genvar i = 0; i < NUM_QP; i++) begin : g_q
      // R11: consuming from an empty submission ring is flagged
      a_r11_sq_adv_empty: assert property (@(posedge clk) disable iff (!rst_n)
        sq_adv[i] && sq_empty[i] |=> adv_err);

      // R11: posting into a full completion ring is flagged
      a_r11_cq_adv_full: assert property (@(posedge clk) disable iff (!rst_n)
        cq_adv[i] && cq_full[i] |=> adv_err);

      // R5: a ring is never reported full and empty together
      a_r5_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        sq_full[i] |-> !sq_empty[i]);

      // R6: an accepted completion post raises the count by one
      a_r6_cq_step: assert property (@(posedge clk) disable iff (!rst_n)
        cq_adv[i] && !cq_full[i] && !cfg_we && !db_valid |=>
          adv_err || (cq_count[i*PTR_W +: PTR_W] == $past(cq_count[i*PTR_W +: PTR_W]) + 1'b1));
    end
  endgenerate
endmodule

bind queue_tracker qt_checker #(
  .NUM_QP (NUM_QP),
  .PTR_W  (PTR_W),
  .ADDR_W (ADDR_W)
) u_qt_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .db_valid (db_valid),
  .db_ready (db_ready),
  .db_addr  (db_addr),
  .db_err   (db_err),
  .sq_adv   (sq_adv),
  .cq_adv   (cq_adv),
  .adv_err  (adv_err),
  .sq_empty (sq_empty),
  .sq_full  (sq_full),
  .cq_full  (cq_full),
  .cq_count (cq_count)
);

// File: tb/test_queue_tracker.sv
module test_queue_tracker;
  localparam int NQ = 3;
  localparam int PW = 16;
  localparam int AW = 16;
  localparam int QW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [QW-1:0] cfg_qid = '0;
  logic cfg_cq = 1'b0;
  logic [PW-1:0] cfg_size = '0;
  logic cfg_err;
  logic db_valid = 1'b0;
  logic db_ready;
  logic [AW-1:0] db_addr = '0;
  logic [PW-1:0] db_data = '0;
  logic db_err;
  logic [NQ-1:0] sq_adv = '0;
  logic [NQ-1:0] cq_adv = '0;
  logic adv_err;
  logic [NQ-1:0] sq_empty, sq_full, cq_empty, cq_full;
  logic [NQ*PW-1:0] sq_count, cq_count, sq_slot, cq_slot;

  always #10 clk = ~clk;  // 50 MHz

  queue_tracker #(.NUM_QP(NQ), .PTR_W(PW), .ADDR_W(AW)) i_queue_tracker (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_qid(cfg_qid), .cfg_cq(cfg_cq), .cfg_size(cfg_size), .cfg_err(cfg_err),
    .db_valid(db_valid), .db_ready(db_ready), .db_addr(db_addr), .db_data(db_data), .db_err(db_err),
    .sq_adv(sq_adv), .cq_adv(cq_adv), .adv_err(adv_err),
    .sq_empty(sq_empty), .sq_full(sq_full), .cq_empty(cq_empty), .cq_full(cq_full),
    .sq_count(sq_count), .cq_count(cq_count), .sq_slot(sq_slot), .cq_slot(cq_slot)
  );

  // Expected ring view: ring = 2*qid + (1 for completion side)
  typedef struct {
    int    ring;
    int    cnt;
    bit    full;
    int    slot;
    bit [2:0] err;   // {db_err, adv_err, cfg_err}
    string tag;
  } item_t;

  item_t sb[$];
  event  chk_ev;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  localparam bit [2:0] E_NONE = 3'b000, E_DB = 3'b100, E_ADV = 3'b010, E_CFG = 3'b001;

  // Monitor: pops expected items and compares with the ports
  initial forever begin
    @(chk_ev);
    while (sb.size() > 0) begin
      item_t it;
      int q, a_cnt, a_slot;
      bit a_full, a_empty;
      bit [2:0] a_err;
      it = sb.pop_front();
      q  = it.ring / 2;
      if (it.ring % 2 == 1) begin
        a_cnt = int'(cq_count[q*PW +: PW]); a_slot = int'(cq_slot[q*PW +: PW]);
        a_full = cq_full[q]; a_empty = cq_empty[q];
      end else begin
        a_cnt = int'(sq_count[q*PW +: PW]); a_slot = int'(sq_slot[q*PW +: PW]);
        a_full = sq_full[q]; a_empty = sq_empty[q];
      end
      a_err = {db_err, adv_err, cfg_err};
      n_chk++;
      if (a_cnt != it.cnt || a_full != it.full || a_empty != (it.cnt == 0) ||
          a_slot != it.slot || a_err != it.err) begin
        n_bad++;
        $display("FAIL %s ring %0d: cnt/full/empty/slot/err actual %0d/%0d/%0d/%0d/%b expected %0d/%0d/%0d/%0d/%b",
                 it.tag, it.ring, a_cnt, a_full, a_empty, a_slot, a_err,
                 it.cnt, it.full, (it.cnt == 0), it.slot, it.err);
      end
    end
  end

  task automatic want(input int ring, input int cnt, input bit full, input int slot,
                      input bit [2:0] err, input string tag);
    item_t it;
    it.ring = ring; it.cnt = cnt; it.full = full; it.slot = slot; it.err = err; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic flush();
    -> chk_ev;
    #1;
  endtask

  task automatic drive(input bit c_we, input int c_qid, input bit c_cq, input int c_sz,
                       input bit d_v, input int d_a, input int d_d,
                       input int s_m, input int c_m);
    @(negedge clk);
    cfg_we = c_we; cfg_qid = QW'(c_qid); cfg_cq = c_cq; cfg_size = PW'(c_sz);
    db_valid = d_v; db_addr = AW'(d_a); db_data = PW'(d_d);
    sq_adv = NQ'(s_m); cq_adv = NQ'(c_m);
    @(negedge clk);
    cfg_we = 1'b0; db_valid = 1'b0; sq_adv = '0; cq_adv = '0;
  endtask

  task automatic do_cfg(input int qid, input bit cq, input int sz);
    drive(1'b1, qid, cq, sz, 1'b0, 0, 0, 0, 0);
  endtask
  task automatic do_db(input int addr, input int val);
    drive(1'b0, 0, 1'b0, 0, 1'b1, addr, val, 0, 0);
  endtask
  task automatic do_adv(input int s_m, input int c_m);
    drive(1'b0, 0, 1'b0, 0, 1'b0, 0, 0, s_m, c_m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset view of every ring
    for (int r = 0; r < 2*NQ; r++) want(r, 0, 1'b0, 0, E_NONE, "R1 reset");
    flush();
    // R12: ready after reset
    n_chk++;
    if (db_ready !== 1'b1) begin
      n_bad++; $display("FAIL R12 db_ready actual %b expected 1", db_ready);
    end

    // R3: admin size field 4096 refused, R2: size field 0 refused
    do_cfg(0, 1'b0, 4096); want(0, 0, 1'b0, 0, E_CFG, "R3 admin over limit"); flush();
    do_cfg(0, 1'b0, 0);    want(0, 0, 1'b0, 0, E_CFG, "R2 size zero"); flush();
    do_cfg(3, 1'b0, 3);    want(0, 0, 1'b0, 0, E_CFG, "R2 qid out of range"); flush();
    // R2: admin submission ring of 4 entries
    do_cfg(0, 1'b0, 3);    want(0, 0, 1'b0, 0, E_NONE, "R2 admin create"); flush();
    // R3: I/O ring of 65536 entries
    do_cfg(1, 1'b0, 65535); want(2, 0, 1'b0, 0, E_NONE, "R3 io max size"); flush();
    // R5: tail 65535 fills the big ring
    do_db(32'h1008, 65535); want(2, 65535, 1'b1, 0, E_NONE, "R5 big ring full"); flush();
    do_adv(3'b010, 0);      want(2, 65534, 1'b0, 1, E_NONE, "R5 big ring consume"); flush();

    // R5: admin ring full at 3 of 4
    do_db(32'h1000, 3); want(0, 3, 1'b1, 0, E_NONE, "R5 admin full"); flush();
    do_adv(3'b001, 0);  want(0, 2, 1'b0, 1, E_NONE, "R5 consume 1"); flush();
    do_adv(3'b001, 0);  want(0, 1, 1'b0, 2, E_NONE, "R5 consume 2"); flush();
    do_adv(3'b001, 0);  want(0, 0, 1'b0, 3, E_NONE, "R5 consume 3"); flush();
    // R7: tail written past the end wraps in count
    do_db(32'h1000, 1); want(0, 2, 1'b0, 3, E_NONE, "R7 tail wrap"); flush();
    do_adv(3'b001, 0);  want(0, 1, 1'b0, 0, E_NONE, "R7 head wrap"); flush();
    // R8: value equal to the entry count
    do_db(32'h1000, 4); want(0, 1, 1'b0, 0, E_DB, "R8 value too large"); flush();
    // R9: tail pulled back below posted work
    do_db(32'h1000, 0); want(0, 1, 1'b0, 0, E_DB, "R9 sq retreat"); flush();
    // R4: bad addresses
    do_db(32'h1002, 2); want(0, 1, 1'b0, 0, E_DB, "R4 misaligned"); flush();
    do_db(32'h0FFC, 2); want(0, 1, 1'b0, 0, E_DB, "R4 below base"); flush();
    do_db(32'h1018, 2); want(0, 1, 1'b0, 0, E_DB, "R4 beyond map"); flush();
    // R10: uncreated ring
    do_db(32'h1010, 0); want(4, 0, 1'b0, 0, E_DB, "R10 uncreated"); flush();
    // R13: doorbell and advance together (head 0->1, tail 1->3)
    drive(1'b0, 0, 1'b0, 0, 1'b1, 32'h1000, 3, 3'b001, 0);
    want(0, 2, 1'b0, 1, E_NONE, "R13 same cycle"); flush();

    // R6: completion ring of 3 entries on qid 2
    do_cfg(2, 1'b1, 2);  want(5, 0, 1'b0, 0, E_NONE, "R2 cq create"); flush();
    do_adv(0, 3'b100);   want(5, 1, 1'b0, 1, E_NONE, "R6 post 1"); flush();
    do_adv(0, 3'b100);   want(5, 2, 1'b1, 2, E_NONE, "R6 post 2 full"); flush();
    do_adv(0, 3'b100);   want(5, 2, 1'b1, 2, E_ADV, "R11 post when full"); flush();
    do_db(32'h1014, 3);  want(5, 2, 1'b1, 2, E_DB, "R8 cq head too large"); flush();
    do_db(32'h1014, 1);  want(5, 1, 1'b0, 2, E_NONE, "R6 head doorbell"); flush();
    do_db(32'h1014, 0);  want(5, 1, 1'b0, 2, E_DB, "R9 cq head past tail"); flush();
    do_adv(0, 3'b100);   want(5, 2, 1'b1, 0, E_NONE, "R7 cq tail wrap"); flush();
    // R11: consume from uncreated submission ring
    do_adv(3'b100, 0);   want(4, 0, 1'b0, 0, E_ADV, "R11 sq empty adv"); flush();
    // R3: admin completion ring at its limit
    do_cfg(0, 1'b1, 4095); want(1, 0, 1'b0, 0, E_NONE, "R3 admin at limit"); flush();
    // R2: reconfiguration clears indices
    do_cfg(0, 1'b0, 1);  want(0, 0, 1'b0, 0, E_NONE, "R2 reconfigure"); flush();
    do_db(32'h1000, 1);  want(0, 1, 1'b1, 0, E_NONE, "R5 two-entry full"); flush();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule